// File: doc/BRIEF.md
# Oversampling Modulator Timing and Power Controller

This block is the digital control core of a one- or two-channel single-bit oversampling converter front end. A fast free-running reference clock (`clk`) oversamples the master clock `mclk`. Every fourth recognised master-clock rising edge produces a bit-rate strobe, and on that strobe each active channel registers its 1-bit loop decision onto its data output. A rising edge on `sync_in` realigns the divide-by-four phase so that several converters can share one sampling instant. The input is sampled on a master-clock falling edge and takes effect on the following rising edge.

Each channel has its own power-down pin, data output and over-range flag. A watchdog counts reference-clock cycles since the last master-clock edge. When the master clock stops for longer than the timeout, every channel goes to a clock-lost power-down state whatever its pin says. While a channel is powered down, its output enables drop so that the pins can be treated as high impedance. The over-range flag rises when the loop reports instability. It clears only after a run of consecutive clean master-clock cycles.

Top module: `mod_timing_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `bit_stb`, `dout`, `dout_oe`, `flag` and `flag_oe` are 0 and every `pmode` field is 0.
- R2: An `mclk` transition is recognised SYNC_STAGES+1 `clk` cycles after it is sampled. `bit_stb` is a one-cycle pulse on every fourth recognised `mclk` rising edge, and the first rising edge after reset is a strobe edge.
- R3: `sync_in` is sampled at each recognised `mclk` falling edge. When it is sampled high after having been sampled low, the next recognised rising edge becomes phase zero: it gives a strobe, and the count of four restarts from it.
- R4: When `sync_in` is held high, it causes no realignment after the first one.
- R5: When `pwdn[c]` is high, the next cycle shows `dout_oe[c]`=0, `flag_oe[c]`=0, `dout[c]`=0 and `flag[c]`=0. The channel's flag state returns to normal.
- R6: Field `pmode[2c+1:2c]` reads 0 when running, 1 when powered down by pin and 2 when the clock is lost. Clock loss takes priority over the pin.
- R7: On a `bit_stb` cycle an active channel's `dout` takes the value of `loop_bit[c]` sampled at that edge. Between strobes, `dout` holds.
- R8: After LOSS_TIMEOUT `clk` cycles with no recognised `mclk` edge, every channel powers down (outputs disabled, mode 2) regardless of `pwdn`. A shorter gap has no effect.
- R9: The first recognised `mclk` rising edge after clock loss clears the loss and is phase zero, so it gives a strobe. The channels are active again from the following cycle.
- R10: In normal mode, `flag[c]` rises on a recognised `mclk` rising edge at which `loop_unstable[c]` is sampled high.
- R11: While the flag is set, `flag[c]` clears on the RECOVER_CYCLES-th consecutive recognised rising edge with `loop_unstable[c]` low. A high sample restarts that count, so repeated bursts of instability give repeated flag pulses.
- R12: Each channel's power-down, data and flag act independently of the other channel. Clock, sync and watchdog are shared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock that oversamples `mclk` |
| rst | input | 1 | Synchronous active-high reset |
| mclk | input | 1 | Master clock (asynchronous to `clk`) |
| sync_in | input | 1 | Phase realignment request |
| pwdn | input | NCH | Per-channel power-down pins |
| loop_bit | input | NCH | 1-bit loop decisions from the analog model |
| loop_unstable | input | NCH | Per-channel loop instability indication |
| bit_stb | output | 1 | One-cycle bit-rate strobe |
| dout | output | NCH | Per-channel serial data bits |
| dout_oe | output | NCH | Data output enables |
| flag | output | NCH | Per-channel over-range flags |
| flag_oe | output | NCH | Flag output enables |
| pmode | output | 2*NCH | Per-channel power mode fields |

## Verification
The bench builds the block with two channels, two synchroniser stages, and a master clock period of 48 reference cycles. It keeps the recovery run at 32 but shortens the loss timeout to 200 reference cycles. The short timeout puts clock-loss entry, sub-timeout gaps and restart at phase zero within a short run. Two channels let power-down by pin and over-range bursts on one channel be checked against an undisturbed neighbour.

// File: rtl/mod_tc_pkg.sv
package mod_tc_pkg;
  typedef enum logic [1:0] {
    PM_RUN      = 2'd0,
    PM_PD_PIN   = 2'd1,
    PM_PD_NOCLK = 2'd2
  } pmode_e;

  typedef enum logic {
    LOOP_HIGH_ORDER  = 1'b0,
    LOOP_FIRST_ORDER = 1'b1
  } loop_e;
endpackage

// File: rtl/mod_tc_edge.sv
// Oversamples the master clock and reports its edges as one-cycle pulses.
module mod_tc_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic mclk,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sh;
  logic              last;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= mclk;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-2:0], mclk};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last <= 1'b0;
    else     last <= sh[STAGES-1];
  end

  assign rise = sh[STAGES-1] & ~last;
  assign fall = ~sh[STAGES-1] & last;
endmodule

// File: rtl/mod_tc_watchdog.sv
// Declares the master clock lost after TIMEOUT reference cycles without an edge.
module mod_tc_watchdog #(
  parameter int TIMEOUT = 4000
) (
  input  logic clk,
  input  logic rst,
  input  logic rise,
  input  logic fall,
  output logic lost
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      lost <= 1'b0;
    end else if (rise || fall) begin
      cnt <= '0;
      if (rise) lost <= 1'b0;
    end else if (!lost) begin
      if (cnt == LIMIT) lost <= 1'b1;
      else              cnt  <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mod_tc_phase.sv
// Divide-by-DIV phase counter with sync realignment and restart after clock loss.
module mod_tc_phase #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic rise,
  input  logic fall,
  input  logic sync_in,
  input  logic lost,
  output logic tick,
  output logic bit_stb
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase_q;
  logic          sync_seen;
  logic          arm;

  assign tick = rise & (arm | lost | (phase_q == LAST));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= LAST;
      sync_seen <= 1'b0;
      arm       <= 1'b0;
      bit_stb   <= 1'b0;
    end else begin
      if (fall) begin
        sync_seen <= sync_in;
        if (sync_in && !sync_seen) arm <= 1'b1;
      end
      if (rise) begin
        if (arm || lost) begin
          phase_q <= '0;
          arm     <= 1'b0;
        end else if (phase_q == LAST) begin
          phase_q <= '0;
        end else begin
          phase_q <= phase_q + 1'b1;
        end
      end
      bit_stb <= tick;
    end
  end
endmodule

// File: rtl/mod_tc_channel.sv
// One channel: power gating, data register and over-range flag state machine.
module mod_tc_channel
  import mod_tc_pkg::*;
#(
  parameter int RECOVER = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rise,
  input  logic       tick,
  input  logic       lost,
  input  logic       pwdn,
  input  logic       loop_bit,
  input  logic       loop_unstable,
  output logic       dout,
  output logic       dout_oe,
  output logic       flag,
  output logic       flag_oe,
  output logic [1:0] pmode
);
  localparam int CW = $clog2(RECOVER + 1);
  localparam logic [CW-1:0] LIMIT = CW'(RECOVER - 1);

  loop_e         st;
  logic [CW-1:0] clean;
  logic          active;

  assign active = ~pwdn & ~lost;

  always_ff @(posedge clk) begin
    if (rst) begin
      pmode <= PM_RUN;
    end else if (lost) begin
      pmode <= PM_PD_NOCLK;
    end else if (pwdn) begin
      pmode <= PM_PD_PIN;
    end else begin
      pmode <= PM_RUN;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      st      <= LOOP_HIGH_ORDER;
      clean   <= '0;
      dout    <= 1'b0;
      dout_oe <= 1'b0;
      flag    <= 1'b0;
      flag_oe <= 1'b0;
    end else begin
      dout_oe <= 1'b1;
      flag_oe <= 1'b1;
      if (tick) dout <= loop_bit;
      if (rise) begin
        case (st)
          LOOP_HIGH_ORDER: begin
            if (loop_unstable) begin
              st    <= LOOP_FIRST_ORDER;
              flag  <= 1'b1;
              clean <= '0;
            end
          end
          default: begin
            if (loop_unstable) begin
              clean <= '0;
            end else if (clean == LIMIT) begin
              st    <= LOOP_HIGH_ORDER;
              flag  <= 1'b0;
              clean <= '0;
            end else begin
              clean <= clean + 1'b1;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/mod_timing_ctrl.sv
module mod_timing_ctrl #(
  parameter int NCH          = 2,
  parameter int SYNC_STAGES  = 2,
  parameter int DIV          = 4,
  parameter int LOSS_TIMEOUT = 4000,
  parameter int RECOVER      = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mclk,
  input  logic             sync_in,
  input  logic [NCH-1:0]   pwdn,
  input  logic [NCH-1:0]   loop_bit,
  input  logic [NCH-1:0]   loop_unstable,
  output logic             bit_stb,
  output logic [NCH-1:0]   dout,
  output logic [NCH-1:0]   dout_oe,
  output logic [NCH-1:0]   flag,
  output logic [NCH-1:0]   flag_oe,
  output logic [2*NCH-1:0] pmode
);
  logic rise, fall, lost, tick;

  mod_tc_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .mclk(mclk), .rise(rise), .fall(fall)
  );

  mod_tc_watchdog #(.TIMEOUT(LOSS_TIMEOUT)) u_wdog (
    .clk(clk), .rst(rst), .rise(rise), .fall(fall), .lost(lost)
  );

  mod_tc_phase #(.DIV(DIV)) u_phase (
    .clk(clk), .rst(rst), .rise(rise), .fall(fall), .sync_in(sync_in),
    .lost(lost), .tick(tick), .bit_stb(bit_stb)
  );

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_ch
      mod_tc_channel #(.RECOVER(RECOVER)) u_ch (
        .clk(clk), .rst(rst), .rise(rise), .tick(tick), .lost(lost),
        .pwdn(pwdn[g]), .loop_bit(loop_bit[g]),
        .loop_unstable(loop_unstable[g]),
        .dout(dout[g]), .dout_oe(dout_oe[g]), .flag(flag[g]),
        .flag_oe(flag_oe[g]), .pmode(pmode[2*g +: 2])
      );
    end
  endgenerate
endmodule

// File: rtl/mod_timing_chk.sv
module mod_timing_chk #(
  parameter int NCH = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [NCH-1:0]   pwdn,
  input logic [NCH-1:0]   loop_unstable,
  input logic             bit_stb,
  input logic [NCH-1:0]   dout,
  input logic [NCH-1:0]   dout_oe,
  input logic [NCH-1:0]   flag,
  input logic [NCH-1:0]   flag_oe,
  input logic [2*NCH-1:0] pmode
);
  // R2
  stb_single_chk: assert property (@(posedge clk) disable iff (rst)
    bit_stb |=> !bit_stb);

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_c
      // R5
      pwdn_tristate_chk: assert property (@(posedge clk) disable iff (rst)
        pwdn[c] |=> (!dout_oe[c] && !flag_oe[c] && !flag[c]));
      // R10
      flag_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag[c]) |-> $past(loop_unstable[c]));
      // R7
      dout_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (dout_oe[c] && $past(dout_oe[c]) && !bit_stb) |-> $stable(dout[c]));
      // R6
      pmode_legal_chk: assert property (@(posedge clk) disable iff (rst)
        pmode[2*c +: 2] != 2'd3);
      // R6
      pmode_oe_chk: assert property (@(posedge clk) disable iff (rst)
        (pmode[2*c +: 2] != 2'd0) |-> !dout_oe[c]);
      // R11
      flag_oe_chk: assert property (@(posedge clk) disable iff (rst)
        flag[c] |-> flag_oe[c]);
    end
  endgenerate
endmodule

bind mod_timing_ctrl mod_timing_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/tb_mod_timing_ctrl.sv
module tb_mod_timing_ctrl;
  localparam int NCH   = 2;
  localparam int TO    = 200;
  localparam int REC   = 32;
  localparam int MHALF = 24;

  logic clk = 1'b0;
  logic rst, mclk, sync_in;
  logic [NCH-1:0] pwdn, loop_bit, loop_unstable;
  logic bit_stb;
  logic [NCH-1:0] dout, dout_oe, flag, flag_oe;
  logic [2*NCH-1:0] pmode;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  bit mclk_run = 0;

  always #5 clk = ~clk;

  mod_timing_ctrl #(.NCH(NCH), .SYNC_STAGES(2), .DIV(4),
                    .LOSS_TIMEOUT(TO), .RECOVER(REC)) dut (
    .clk(clk), .rst(rst), .mclk(mclk), .sync_in(sync_in), .pwdn(pwdn),
    .loop_bit(loop_bit), .loop_unstable(loop_unstable), .bit_stb(bit_stb),
    .dout(dout), .dout_oe(dout_oe), .flag(flag), .flag_oe(flag_oe),
    .pmode(pmode)
  );

  // ---------------- reference model ----------------
  int s[4];
  int m_phase, m_arm, m_sprev, m_lost, m_cnt, m_stb;
  int m_st[NCH], m_rc[NCH], m_dout[NCH], m_flag[NCH], m_oe[NCH], m_mode[NCH];

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) s[i] = 0;
      m_phase = 3; m_arm = 0; m_sprev = 0; m_lost = 0; m_cnt = 0; m_stb = 0;
      for (int c = 0; c < NCH; c++) begin
        m_st[c] = 0; m_rc[c] = 0; m_dout[c] = 0; m_flag[c] = 0;
        m_oe[c] = 0; m_mode[c] = 0;
      end
    end else begin
      int rise, fall, tick, o_lost;
      s[3] = s[2]; s[2] = s[1]; s[1] = s[0]; s[0] = int'(mclk);
      rise = (s[2] == 1 && s[3] == 0) ? 1 : 0;
      fall = (s[2] == 0 && s[3] == 1) ? 1 : 0;
      o_lost = m_lost;
      tick = 0;
      if (rise == 1) begin
        if (m_arm == 1 || o_lost == 1) begin
          m_phase = 0; m_arm = 0; tick = 1;
        end else begin
          m_phase = (m_phase + 1) % 4;
          tick = (m_phase == 0) ? 1 : 0;
        end
      end
      if (fall == 1) begin
        if (sync_in && m_sprev == 0) m_arm = 1;
        m_sprev = int'(sync_in);
      end
      m_stb = tick;
      if (rise == 1 || fall == 1) begin
        m_cnt = 0;
        if (rise == 1) m_lost = 0;
      end else if (m_lost == 0) begin
        if (m_cnt == TO - 1) m_lost = 1;
        else m_cnt++;
      end
      for (int c = 0; c < NCH; c++) begin
        m_mode[c] = (o_lost == 1) ? 2 : (pwdn[c] ? 1 : 0);
        if (pwdn[c] || o_lost == 1) begin
          m_st[c] = 0; m_rc[c] = 0; m_dout[c] = 0; m_flag[c] = 0; m_oe[c] = 0;
        end else begin
          m_oe[c] = 1;
          if (tick == 1) m_dout[c] = int'(loop_bit[c]);
          if (rise == 1) begin
            if (m_st[c] == 0) begin
              if (loop_unstable[c]) begin m_st[c] = 1; m_flag[c] = 1; m_rc[c] = 0; end
            end else if (loop_unstable[c]) begin
              m_rc[c] = 0;
            end else if (m_rc[c] == REC - 1) begin
              m_st[c] = 0; m_flag[c] = 0; m_rc[c] = 0;
            end else begin
              m_rc[c]++;
            end
          end
        end
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && !done) begin
        check("bit_stb R2 R3 R4 R9", int'(bit_stb), m_stb);
        for (int c = 0; c < NCH; c++) begin
          check("dout R7 R12", int'(dout[c]), m_dout[c]);
          check("oe R5 R8", int'(dout_oe[c]), m_oe[c]);
          check("flag_oe R5", int'(flag_oe[c]), m_oe[c]);
          check("flag R10 R11", int'(flag[c]), m_flag[c]);
          check("pmode R6 R8 R9", int'(pmode[2*c +: 2]), m_mode[c]);
        end
      end
    end
  end

  // master clock generator
  initial begin
    int mc = 0;
    mclk = 1'b0;
    forever begin
      @(negedge clk);
      if (mclk_run) begin
        if (mc == MHALF - 1) begin mclk = ~mclk; mc = 0; end
        else mc++;
      end
    end
  end

  // pseudo-random loop decisions
  initial begin
    logic [7:0] lf = 8'hA5;
    loop_bit = '0;
    forever begin
      repeat (7) @(negedge clk);
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      loop_bit = lf[1:0];
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_m(input int n);
    wait_clk(n * 2 * MHALF);
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst = 1'b1; sync_in = 1'b0; pwdn = '0; loop_unstable = '0;
    wait_clk(5);
    // R1 reset state
    check("reset R1 bit_stb", int'(bit_stb), 0);
    check("reset R1 dout", int'(dout), 0);
    check("reset R1 oe", int'(dout_oe | flag_oe), 0);
    check("reset R1 flag", int'(flag), 0);
    check("reset R1 pmode", int'(pmode), 0);
    rst = 1'b0;
    mclk_run = 1;
    wait_m(20);
    // R3 realignment at an odd offset
    wait_clk(37); sync_in = 1'b1; wait_m(3); sync_in = 1'b0; wait_m(5);
    // R4 steady high level
    wait_clk(70); sync_in = 1'b1; wait_m(12); sync_in = 1'b0; wait_m(4);
    wait_clk(100); sync_in = 1'b1; wait_clk(30); sync_in = 1'b0; wait_m(6);
    // R5 R12 channel 1 powered down, channel 0 keeps running
    pwdn[1] = 1'b1; wait_m(10);
    check("R5 ch1 oe", int'(dout_oe[1]), 0);
    check("R12 ch0 oe", int'(dout_oe[0]), 1);
    check("R6 ch1 mode", int'(pmode[3:2]), 1);
    pwdn[1] = 1'b0; wait_m(6);
    // R10 R11 channel 0 burst and recovery with an interruption
    loop_unstable[0] = 1'b1; wait_m(3);
    check("R10 flag set", int'(flag[0]), 1);
    loop_unstable[0] = 1'b0; wait_m(20);
    loop_unstable[0] = 1'b1; wait_m(1);
    loop_unstable[0] = 1'b0; wait_m(20);
    check("R11 count restarted", int'(flag[0]), 1);
    wait_m(20);
    check("R11 flag cleared", int'(flag[0]), 0);
    // R11 repeated bursts on channel 1
    for (int k = 0; k < 5; k++) begin
      loop_unstable[1] = 1'b1; wait_m(2);
      loop_unstable[1] = 1'b0; wait_m(34);
    end
    // R5 power-down while flagged
    loop_unstable[0] = 1'b1; wait_m(2); pwdn[0] = 1'b1; wait_m(2);
    check("R5 flag dropped", int'(flag[0]), 0);
    loop_unstable[0] = 1'b0; pwdn[0] = 1'b0; wait_m(4);
    // R8 short gap tolerated
    mclk_run = 0; wait_clk(100); mclk_run = 1; wait_m(6);
    check("R8 short gap mode", int'(pmode), 0);
    // R8 R6 clock lost with a pin also high
    pwdn[0] = 1'b1;
    mclk_run = 0; wait_clk(TO + 80);
    check("R8 ch0 mode", int'(pmode[1:0]), 2);
    check("R8 ch1 mode", int'(pmode[3:2]), 2);
    check("R8 ch1 oe", int'(dout_oe[1]), 0);
    // R9 restart at phase zero
    mclk_run = 1; wait_m(10);
    check("R9 ch0 pin mode", int'(pmode[1:0]), 1);
    check("R9 ch1 running", int'(pmode[3:2]), 0);
    pwdn[0] = 1'b0; wait_m(10);
    finish_run();
  end
endmodule